// File: doc/BRIEF.md
# Serial Receive Status and Error Controller

This block keeps the receive-side control and status flags of a serial port that works either asynchronously (UART framing) or as a clocked synchronous link. A separate shift engine reports three things per frame: that a frame has started, that it has completed, and whether it had a framing fault. It also supplies the frame's data and the received parity bit. The block takes a CPU write of the receive-enable bit and a strobe that marks a CPU read of the receive buffer's low byte.

From these inputs the block decides whether each completed frame is copied into the receive buffer. It keeps the busy, finished, overrun, parity, framing and error-sum flags. It also emits one-cycle interrupt and DMA request pulses. Overrun is sticky. While overrun is set, the buffer is frozen and CPU reads leave the finished and error flags untouched. The only way to recover is to write the enable bit to 0, which resets the whole receive side.

Top module: `rx_status_ctrl`

## Requirements
- R1: `rx_busy` goes to 1 in the cycle after an enabled `rx_start`. It returns to 0 after an enabled `rx_done`, or after enable is written to 0. If start and done arrive in the same cycle, start wins.
- R2: `rx_finished` goes to 1 in the cycle after a completed frame is loaded into `rx_buf`. It returns to 0 after a `buf_rd_lo` strobe, provided overrun is clear.
- R3: Writing enable to 0 (`en_wr`=1, `en_wdata`=0) clears `rx_en` and all of the following in the next cycle: busy, finished, overrun, parity, framing and error-sum. `rx_buf` keeps its contents.
- R4: When a frame completes while `rx_finished` is 1 and there is no read in the same cycle, `rx_overrun` goes to 1 and `rx_buf` keeps its previous value.
- R5: A frame that ends in overrun raises neither `rx_irq` nor `rx_dma_req`. `rx_dma_req` is never high without `rx_irq`.
- R6: Once set, overrun stays set until enable is written to 0. While it is set, `buf_rd_lo` does not clear finished, parity or framing, and later frames are not stored.
- R7: A parity mismatch is flagged only when `mode_async`=1 and `parity_en`=1. With `parity_odd`=0 the ones in the data plus the parity bit must be even; with `parity_odd`=1 they must be odd. In synchronous mode the flag stays 0.
- R8: A frame with a parity error is still stored and sets `rx_parity_err`. It raises `rx_irq` but not `rx_dma_req`.
- R9: In asynchronous mode, `rx_frame_err` on a stored frame sets `rx_framing_err`. That frame raises `rx_irq` but not `rx_dma_req`. In synchronous mode the framing flag stays 0.
- R10: `rx_err_sum` equals the OR of overrun, parity and framing.
- R11: When a read and a frame completion fall in the same cycle, the read is taken first. The new frame is then stored, with interrupt and DMA pulses, and no overrun is flagged.
- R12: A write of enable to 0 overrides a start, done or read in the same cycle.
- R13: While enable is 0, start, done and read strobes have no effect on flags, pulses or `rx_buf`.
- R14: `rx_irq` and `rx_dma_req` are one-cycle pulses. They appear in the same cycle as the new `rx_buf` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_async | input | 1 | 1 = UART framing, 0 = clocked synchronous |
| parity_en | input | 1 | Parity checking on |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| en_wr | input | 1 | CPU write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| rx_start | input | 1 | Frame-start pulse from the shift engine |
| rx_done | input | 1 | Frame-complete pulse from the shift engine |
| rx_data | input | DW | Frame data, valid with `rx_done` |
| rx_par_bit | input | 1 | Received parity bit, valid with `rx_done` |
| rx_frame_err | input | 1 | Framing fault, valid with `rx_done` |
| buf_rd_lo | input | 1 | CPU read strobe for the buffer's low byte |
| rx_en | output | 1 | Current enable bit |
| rx_busy | output | 1 | Frame in progress |
| rx_finished | output | 1 | Buffer holds unread data |
| rx_overrun | output | 1 | Sticky overrun flag |
| rx_parity_err | output | 1 | Parity error on the stored frame |
| rx_framing_err | output | 1 | Framing error on the stored frame |
| rx_err_sum | output | 1 | OR of the three error flags |
| rx_buf | output | DW | Receive buffer |
| rx_irq | output | 1 | Receive-complete interrupt pulse |
| rx_dma_req | output | 1 | DMA request pulse |

## Verification
The hardest state to reach is overrun, followed by a read that must be ignored and then a further frame that must not be stored. Reaching it takes a loaded buffer, a second completion with no read, then a read and a start/done pair while the error is held. The vector walk builds this chain in order and then clears it with an enable write. It also places a read on the same cycle as a completion, and an enable-clear on the same cycle as a start, so that both priority rules are exercised.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    // registered flag state of the receive side
    typedef struct packed {
        logic en;
        logic busy;
        logic fin;
        logic ovr;
        logic par;
        logic frm;
        logic irq;
        logic dma;
    } rxs_flags_t;

    // qualified events for one cycle
    typedef struct packed {
        logic dis;
        logic ena;
        logic start;
        logic done;
        logic rd;
        logic perr;
        logic ferr;
    } rxs_evt_t;

endpackage

// File: rtl/rxs_parity_chk.sv
module rxs_parity_chk #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          par_bit,
    input  logic          odd_sel,
    output logic          mismatch
);
    logic ones_odd;

    always_comb begin
        ones_odd = (^data) ^ par_bit;
        mismatch = (ones_odd != odd_sel);
    end
endmodule

// File: rtl/rxs_evt_qual.sv
module rxs_evt_qual
    import rxs_pkg::*;
(
    input  logic     en_q,
    input  logic     mode_async,
    input  logic     parity_en,
    input  logic     en_wr,
    input  logic     en_wdata,
    input  logic     rx_start,
    input  logic     rx_done,
    input  logic     buf_rd_lo,
    input  logic     par_mismatch,
    input  logic     rx_frame_err,
    output rxs_evt_t evt
);
    logic active;

    always_comb begin
        evt.dis   = en_wr & ~en_wdata;
        evt.ena   = en_wr & en_wdata;
        active    = en_q & ~evt.dis;
        evt.start = active & rx_start;
        evt.done  = active & rx_done;
        evt.rd    = active & buf_rd_lo;
        evt.perr  = mode_async & parity_en & par_mismatch;
        evt.ferr  = mode_async & rx_frame_err;
    end
endmodule

// File: rtl/rxs_flag_next.sv
module rxs_flag_next
    import rxs_pkg::*;
(
    input  rxs_flags_t flags_q,
    input  rxs_evt_t   evt,
    output rxs_flags_t flags_d,
    output logic       load
);
    logic buf_full;

    always_comb begin
        flags_d     = flags_q;
        flags_d.irq = 1'b0;
        flags_d.dma = 1'b0;
        load        = 1'b0;
        buf_full    = flags_q.ovr | (flags_q.fin & ~evt.rd);

        if (evt.dis) begin
            flags_d = '0;
        end else begin
            if (evt.ena) begin
                flags_d.en = 1'b1;
            end
            if (evt.start) begin
                flags_d.busy = 1'b1;
            end else if (evt.done) begin
                flags_d.busy = 1'b0;
            end
            if (evt.rd && !flags_q.ovr) begin
                flags_d.fin = 1'b0;
                flags_d.par = 1'b0;
                flags_d.frm = 1'b0;
            end
            if (evt.done) begin
                if (buf_full) begin
                    flags_d.ovr = 1'b1;
                end else begin
                    load        = 1'b1;
                    flags_d.fin = 1'b1;
                    flags_d.par = evt.perr;
                    flags_d.frm = evt.ferr;
                    flags_d.irq = 1'b1;
                    flags_d.dma = ~(evt.perr | evt.ferr);
                end
            end
        end
    end
endmodule

// File: rtl/rx_status_ctrl.sv
module rx_status_ctrl
    import rxs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_async,
    input  logic          parity_en,
    input  logic          parity_odd,
    input  logic          en_wr,
    input  logic          en_wdata,
    input  logic          rx_start,
    input  logic          rx_done,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_par_bit,
    input  logic          rx_frame_err,
    input  logic          buf_rd_lo,
    output logic          rx_en,
    output logic          rx_busy,
    output logic          rx_finished,
    output logic          rx_overrun,
    output logic          rx_parity_err,
    output logic          rx_framing_err,
    output logic          rx_err_sum,
    output logic [DW-1:0] rx_buf,
    output logic          rx_irq,
    output logic          rx_dma_req
);
    rxs_flags_t    flags_d, flags_q;
    rxs_evt_t      evt;
    logic          mismatch;
    logic          load;
    logic [DW-1:0] buf_d, buf_q;

    rxs_parity_chk #(.DW(DW)) u_par (
        .data     (rx_data),
        .par_bit  (rx_par_bit),
        .odd_sel  (parity_odd),
        .mismatch (mismatch)
    );

    rxs_evt_qual u_qual (
        .en_q         (flags_q.en),
        .mode_async   (mode_async),
        .parity_en    (parity_en),
        .en_wr        (en_wr),
        .en_wdata     (en_wdata),
        .rx_start     (rx_start),
        .rx_done      (rx_done),
        .buf_rd_lo    (buf_rd_lo),
        .par_mismatch (mismatch),
        .rx_frame_err (rx_frame_err),
        .evt          (evt)
    );

    rxs_flag_next u_next (
        .flags_q (flags_q),
        .evt     (evt),
        .flags_d (flags_d),
        .load    (load)
    );

    always_comb begin
        buf_d = load ? rx_data : buf_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            buf_q   <= '0;
        end else begin
            flags_q <= flags_d;
            buf_q   <= buf_d;
        end
    end

    always_comb begin
        rx_en          = flags_q.en;
        rx_busy        = flags_q.busy;
        rx_finished    = flags_q.fin;
        rx_overrun     = flags_q.ovr;
        rx_parity_err  = flags_q.par;
        rx_framing_err = flags_q.frm;
        rx_err_sum     = flags_q.ovr | flags_q.par | flags_q.frm;
        rx_buf         = buf_q;
        rx_irq         = flags_q.irq;
        rx_dma_req     = flags_q.dma;
    end

    // R5: a DMA request only ever accompanies an interrupt
    a_r5_dma_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> rx_irq);

    // R14: an interrupt pulse comes with a loaded, unread buffer
    a_r14_irq_with_fin: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_finished);

    // R3: an enable-clear write leaves every flag low next cycle
    a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !en_wdata) |=> (!rx_en && !rx_busy && !rx_finished &&
                                  !rx_overrun && !rx_err_sum));

    // R6: overrun holds unless enable is cleared
    a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !(en_wr && !en_wdata)) |=> rx_overrun);

    // R4: nothing is stored while overrun is held
    a_r4_buf_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> $stable(rx_buf));

    // R13: while disabled and not being enabled, flags stay clear
    a_r13_idle_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !en_wr) |=> (!rx_busy && !rx_finished && !rx_irq));
endmodule

// File: tb/tb_rx_status_ctrl.sv
module tb_rx_status_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    typedef struct packed {
        logic wr, wv, st, dn, rd, pb, fe;
        logic [7:0] dat;
        logic bsy, fin, ovr, par, frm, irq, dma;
        logic [7:0] bufv;
    } vec_t;

    localparam int NV = 23;
    // stimulus: wr wv st dn rd pb fe dat | expect: bsy fin ovr par frm irq dma buf
    localparam vec_t VEC [NV] = '{
        '{1,1,0,0,0,0,0,8'h00, 0,0,0,0,0,0,0,8'h00}, // 0 enable
        '{0,0,1,0,0,0,0,8'h00, 1,0,0,0,0,0,0,8'h00}, // 1 R1 start
        '{0,0,0,1,0,0,0,8'hA5, 0,1,0,0,0,1,1,8'hA5}, // 2 R2 clean frame
        '{0,0,0,0,0,0,0,8'h00, 0,1,0,0,0,0,0,8'hA5}, // 3 R14 pulse ends
        '{0,0,0,0,1,0,0,8'h00, 0,0,0,0,0,0,0,8'hA5}, // 4 R2 read clears
        '{0,0,1,0,0,0,0,8'h00, 1,0,0,0,0,0,0,8'hA5}, // 5
        '{0,0,0,1,0,1,0,8'h3C, 0,1,0,1,0,1,0,8'h3C}, // 6 R8 parity error
        '{0,0,0,0,1,0,0,8'h00, 0,0,0,0,0,0,0,8'h3C}, // 7 read clears parity
        '{0,0,0,1,0,0,1,8'h0F, 0,1,0,0,1,1,0,8'h0F}, // 8 R9 framing
        '{0,0,0,1,0,0,0,8'h11, 0,1,1,0,1,0,0,8'h0F}, // 9 R4 R5 overrun
        '{0,0,0,0,1,0,0,8'h00, 0,1,1,0,1,0,0,8'h0F}, // 10 R6 read ignored
        '{0,0,1,0,0,0,0,8'h00, 1,1,1,0,1,0,0,8'h0F}, // 11
        '{0,0,0,1,0,0,0,8'h22, 0,1,1,0,1,0,0,8'h0F}, // 12 R6 not stored
        '{1,1,0,0,0,0,0,8'h00, 0,1,1,0,1,0,0,8'h0F}, // 13 re-enable no effect
        '{1,0,0,0,0,0,0,8'h00, 0,0,0,0,0,0,0,8'h0F}, // 14 R3 clear
        '{0,0,0,1,0,0,0,8'h55, 0,0,0,0,0,0,0,8'h0F}, // 15 R13 ignored
        '{1,1,0,0,0,0,0,8'h00, 0,0,0,0,0,0,0,8'h0F}, // 16
        '{0,0,0,1,0,0,0,8'h55, 0,1,0,0,0,1,1,8'h55}, // 17
        '{0,0,0,1,1,0,0,8'h66, 0,1,0,0,0,1,1,8'h66}, // 18 R11 read+done
        '{1,0,1,0,0,0,0,8'h00, 0,0,0,0,0,0,0,8'h66}, // 19 R12 clear beats start
        '{1,1,0,0,0,0,0,8'h00, 0,0,0,0,0,0,0,8'h66}, // 20
        '{0,0,1,0,0,0,0,8'h00, 1,0,0,0,0,0,0,8'h66}, // 21
        '{1,0,0,0,0,0,0,8'h00, 0,0,0,0,0,0,0,8'h66}  // 22 R1 abort
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_async = 1'b1, parity_en = 1'b1, parity_odd = 1'b0;
    logic en_wr = 0, en_wdata = 0, rx_start = 0, rx_done = 0;
    logic [DW-1:0] rx_data = '0;
    logic rx_par_bit = 0, rx_frame_err = 0, buf_rd_lo = 0;
    logic rx_en, rx_busy, rx_finished, rx_overrun, rx_parity_err;
    logic rx_framing_err, rx_err_sum, rx_irq, rx_dma_req;
    logic [DW-1:0] rx_buf;

    int checks = 0;
    int errors = 0;
    logic en_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_status_ctrl #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .mode_async(mode_async),
        .parity_en(parity_en), .parity_odd(parity_odd),
        .en_wr(en_wr), .en_wdata(en_wdata), .rx_start(rx_start),
        .rx_done(rx_done), .rx_data(rx_data), .rx_par_bit(rx_par_bit),
        .rx_frame_err(rx_frame_err), .buf_rd_lo(buf_rd_lo),
        .rx_en(rx_en), .rx_busy(rx_busy), .rx_finished(rx_finished),
        .rx_overrun(rx_overrun), .rx_parity_err(rx_parity_err),
        .rx_framing_err(rx_framing_err), .rx_err_sum(rx_err_sum),
        .rx_buf(rx_buf), .rx_irq(rx_irq), .rx_dma_req(rx_dma_req)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // drive at negedge, let one posedge pass, return at the following negedge
    task automatic step(input logic wr, wv, st, dn, rd, pb, fe, input logic [7:0] dat);
        en_wr = wr; en_wdata = wv; rx_start = st; rx_done = dn;
        buf_rd_lo = rd; rx_par_bit = pb; rx_frame_err = fe; rx_data = dat;
        if (wr) en_m = wv;
        @(posedge clk);
        @(negedge clk);
        en_wr = 0; rx_start = 0; rx_done = 0; buf_rd_lo = 0;
        rx_par_bit = 0; rx_frame_err = 0;
    endtask

    task automatic chk_all(input string ctx, input logic bsy, fin, ovr, par, frm, irq, dma,
                           input logic [7:0] bufv);
        chk({ctx, " R1 busy"},       {7'd0, rx_busy},        {7'd0, bsy});
        chk({ctx, " R2 finished"},   {7'd0, rx_finished},    {7'd0, fin});
        chk({ctx, " R4 overrun"},    {7'd0, rx_overrun},     {7'd0, ovr});
        chk({ctx, " R8 parity"},     {7'd0, rx_parity_err},  {7'd0, par});
        chk({ctx, " R9 framing"},    {7'd0, rx_framing_err}, {7'd0, frm});
        chk({ctx, " R10 err_sum"},   {7'd0, rx_err_sum},     {7'd0, ovr | par | frm});
        chk({ctx, " R14 irq"},       {7'd0, rx_irq},         {7'd0, irq});
        chk({ctx, " R5 dma"},        {7'd0, rx_dma_req},     {7'd0, dma});
        chk({ctx, " R3 enable"},     {7'd0, rx_en},          {7'd0, en_m});
        chk({ctx, " R4 buffer"},     rx_buf,                 bufv);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("reset", 0, 0, 0, 0, 0, 0, 0, 8'h00);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            step(v.wr, v.wv, v.st, v.dn, v.rd, v.pb, v.fe, v.dat);
            chk_all($sformatf("vec%0d", i), v.bsy, v.fin, v.ovr, v.par, v.frm,
                    v.irq, v.dma, v.bufv);
        end

        // R7 R9: synchronous mode masks parity and framing
        mode_async = 1'b0;
        step(1, 1, 0, 0, 0, 0, 0, 8'h00);
        step(0, 0, 0, 1, 0, 1, 1, 8'h3C);
        chk_all("R7 sync", 0, 1, 0, 0, 0, 1, 1, 8'h3C);

        // R7: odd parity sense
        step(1, 0, 0, 0, 0, 0, 0, 8'h00);
        mode_async = 1'b1;
        parity_odd = 1'b1;
        step(1, 1, 0, 0, 0, 0, 0, 8'h00);
        step(0, 0, 0, 1, 0, 0, 0, 8'h01);
        chk_all("R7 odd ok", 0, 1, 0, 0, 0, 1, 1, 8'h01);
        step(0, 0, 0, 0, 1, 0, 0, 8'h00);
        step(0, 0, 0, 1, 0, 0, 0, 8'h03);
        chk_all("R7 odd bad", 0, 1, 0, 1, 0, 1, 0, 8'h03);

        // R7: parity checking off
        parity_en = 1'b0;
        step(0, 0, 0, 0, 1, 0, 0, 8'h00);
        step(0, 0, 0, 1, 0, 0, 0, 8'h03);
        chk_all("R7 par off", 0, 1, 0, 0, 0, 1, 1, 8'h03);

        // R1: start and done together keep busy set
        step(0, 0, 0, 0, 1, 0, 0, 8'h00);
        step(0, 0, 1, 1, 0, 0, 0, 8'h44);
        chk_all("R1 start+done", 1, 1, 0, 0, 0, 1, 1, 8'h44);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule